// File: doc/BRIEF.md
# Quarter-Rate Real/Complex Sample Format Converter

This block turns a stream of real samples into a stream of complex samples, or turns a complex stream back into a real one. Both directions use a frequency shift of exactly one quarter of the sample rate. At that frequency the complex exponential only takes the values 1, j, -1 and -j, so the mixer is built from sign changes and I/Q swaps and has no multipliers.

In real-to-complex mode each accepted real sample is rotated down by a quarter of the sample rate. The rotated sample goes through a fixed 7-tap halfband lowpass filter on the I and Q rails, and the block emits one complex sample per input. In complex-to-real mode each accepted complex sample is followed by an inserted zero, which doubles the rate. The doubled stream goes through the same halfband response with a gain of two, is rotated up by a quarter of the sample rate, and only the real part is emitted. That gives two real outputs per complex input.

Samples enter and leave through valid/ready handshakes. A control state machine has the states IDLE, FLUSH, FILT, HOLD and STUFF. Its transitions are:
- IDLE to FLUSH when the mode pin differs from the active mode.
- IDLE to FILT when a sample is accepted.
- FLUSH to IDLE after clearing.
- FILT to HOLD after the result is registered.
- HOLD to STUFF when the first output of a complex-to-real pair is taken.
- HOLD to IDLE when the last output is taken.
- STUFF to FILT after the zero is pushed.

Top module: `fs4_format_conv`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, the mixer step is 0, the filter history is all zeros and the active mode is real-to-complex.
- R2: In real-to-complex mode (`mode`=0), the n-th accepted real sample x since the last flush is rotated by the step sequence 1, -j, -1, +j. The rotated (I,Q) is (x,0), (0,-x), (-x,0), (0,x) for n mod 4 = 0, 1, 2, 3. Only `in_i` is used.
- R3: In real-to-complex mode the output rails are y = (16·m[n-3] + 9·(m[n-2]+m[n-4]) − m[n] − m[n-6] + 16) >>> 5. Here m is the rotated sequence, m[n] is the newest sample, and the shift is arithmetic. Each rail is filtered on its own and yields one output per input.
- R4: In complex-to-real mode (`mode`=1), each accepted sample s is followed by an inserted zero. The stream s0, 0, s1, 0, … is filtered with the same taps and a doubled gain, v = (Σ taps·u + 8) >>> 4. This yields two outputs per input.
- R5: In complex-to-real mode the k-th output since the last flush is the real part of v·(+j)^k: v_i, −v_q, −v_i, v_q for k mod 4 = 0, 1, 2, 3. `out_q` is always 0.
- R6: While `out_valid` is high and `out_ready` is low, `out_i` and `out_q` hold their values. `in_ready` is low whenever `out_valid` is high.
- R7: When `mode` differs from the active mode, `in_ready` drops at once. One FLUSH cycle then clears the filter history and the mixer step before the next sample is accepted under the new mode.
- R8: An output is valid two clock edges after the sample that produces it is accepted. It is not valid on the first edge.
- R9: Full-scale inputs (−2048 and 2047) produce exact 14-bit results with no wrap in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 = real-to-complex, 1 = complex-to-real |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_i | input | 12 | Real sample, or in-phase part (signed) |
| in_q | input | 12 | Quadrature part in complex-to-real mode (signed) |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_i | output | 14 | In-phase result, or real result (signed) |
| out_q | output | 14 | Quadrature result, or 0 in complex-to-real mode (signed) |

## Verification
A result becomes valid two rising edges after the accepting edge. The second output of a complex-to-real pair becomes valid two edges after the first output's handshake edge, and the next input can be taken one edge after the last handshake. The bench changes inputs and `out_ready` only on falling edges and samples outputs there. It compares an expected item only when valid and ready are both seen high before the handshake edge, so stalls of any length leave the order of results intact. A latency probe checks `out_valid` at the falling edge right after acceptance (low) and one cycle later (high).

// File: rtl/fs4_pkg.sv
package fs4_pkg;

    typedef enum logic {
        MODE_R2C = 1'b0,
        MODE_C2R = 1'b1
    } conv_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_FILT,
        ST_HOLD,
        ST_STUFF
    } conv_state_e;

    // halfband response: taps sum to 2**HB_GAIN_LOG2
    localparam int HB_TAPS      = 7;
    localparam int HB_GAIN_LOG2 = 5;
    localparam int HB_HEADROOM  = 2;

    function automatic int hb_coef(input int k);
        case (k)
            0, 6:    return -1;
            2, 4:    return 9;
            3:       return 16;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fs4_mix_down.sv
module fs4_mix_down #(
    parameter int IN_W  = 12,
    parameter int OUT_W = IN_W + 1
) (
    input  logic signed [IN_W-1:0]  x,
    input  logic        [1:0]       step,
    output logic signed [OUT_W-1:0] rot_i,
    output logic signed [OUT_W-1:0] rot_q
);
    logic signed [OUT_W-1:0] x_ext;
    logic signed [OUT_W-1:0] x_neg;

    assign x_ext = OUT_W'(x);
    assign x_neg = -x_ext;

    always_comb begin
        unique case (step)
            2'd0: begin rot_i = x_ext; rot_q = '0;    end
            2'd1: begin rot_i = '0;    rot_q = x_neg; end
            2'd2: begin rot_i = x_neg; rot_q = '0;    end
            2'd3: begin rot_i = '0;    rot_q = x_ext; end
        endcase
    end
endmodule

// File: rtl/fs4_mix_up.sv
module fs4_mix_up #(
    parameter int W = 14
) (
    input  logic signed [W-1:0] v_i,
    input  logic signed [W-1:0] v_q,
    input  logic        [1:0]   step,
    output logic signed [W-1:0] re
);
    always_comb begin
        unique case (step)
            2'd0: re = v_i;
            2'd1: re = -v_q;
            2'd2: re = -v_i;
            2'd3: re = v_q;
        endcase
    end
endmodule

// File: rtl/fs4_phase.sv
module fs4_phase (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    output logic [1:0] step
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   step <= 2'd0;
        else if (clr) step <= 2'd0;
        else if (adv) step <= step + 2'd1;
    end
endmodule

// File: rtl/fs4_halfband.sv
module fs4_halfband
    import fs4_pkg::*;
#(
    parameter int W     = 13,
    parameter int ACC_W = W + HB_GAIN_LOG2 + HB_HEADROOM
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    push,
    input  logic signed [W-1:0]     din,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [W-1:0] hist [HB_TAPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < HB_TAPS; k++) hist[k] <= '0;
        end else if (clr) begin
            for (int k = 0; k < HB_TAPS; k++) hist[k] <= '0;
        end else if (push) begin
            hist[0] <= din;
            for (int k = 1; k < HB_TAPS; k++) hist[k] <= hist[k-1];
        end
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < HB_TAPS; k++) begin
            acc = acc + ACC_W'(hb_coef(k)) * ACC_W'(hist[k]);
        end
    end
endmodule

// File: rtl/fs4_format_conv.sv
module fs4_format_conv
    import fs4_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_i,
    input  logic [DATA_W-1:0]   in_q,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DATA_W+1:0]   out_i,
    output logic [DATA_W+1:0]   out_q
);
    localparam int LANE_W = DATA_W + 1;
    localparam int OUT_W  = DATA_W + 2;
    localparam int ACC_W  = LANE_W + HB_GAIN_LOG2 + HB_HEADROOM;
    localparam int SH_R2C = HB_GAIN_LOG2;
    localparam int SH_C2R = HB_GAIN_LOG2 - 1;
    localparam int LANES  = 2;

    conv_state_e state, nxt;
    conv_mode_e  mode_q, mode_in;
    logic        second;
    logic [1:0]  phase;
    logic        accept, clr, push, adv;

    logic signed [LANE_W-1:0] mix_i, mix_q;
    logic signed [LANE_W-1:0] hb_in  [LANES];
    logic signed [ACC_W-1:0]  hb_acc [LANES];
    logic signed [ACC_W-1:0]  rnd_r2c [LANES];
    logic signed [ACC_W-1:0]  rnd_c2r [LANES];
    logic signed [OUT_W-1:0]  up_re;
    logic signed [OUT_W-1:0]  res_i, res_q;

    assign mode_in = conv_mode_e'(mode);

    // control strobes
    assign in_ready  = (state == ST_IDLE) && (mode_in == mode_q);
    assign accept    = in_ready && in_valid;
    assign clr       = (state == ST_FLUSH);
    assign push      = accept || (state == ST_STUFF);
    assign out_valid = (state == ST_HOLD);
    assign adv       = (mode_q == MODE_R2C) ? accept : (out_valid && out_ready);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (mode_in != mode_q) nxt = ST_FLUSH;
                else if (in_valid)     nxt = ST_FILT;
            end
            ST_FLUSH: nxt = ST_IDLE;
            ST_FILT:  nxt = ST_HOLD;
            ST_HOLD: begin
                if (out_ready)
                    nxt = (mode_q == MODE_C2R && !second) ? ST_STUFF : ST_IDLE;
            end
            ST_STUFF: nxt = ST_FILT;
            default:  nxt = ST_IDLE;
        endcase
    end

    // mixer step counter
    fs4_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .adv   (adv),
        .step  (phase)
    );

    // down rotation of the real input
    fs4_mix_down #(.IN_W(DATA_W), .OUT_W(LANE_W)) u_down (
        .x     (signed'(in_i)),
        .step  (phase),
        .rot_i (mix_i),
        .rot_q (mix_q)
    );

    // filter input select: rotated real, raw complex, or stuffed zero
    always_comb begin
        if (state == ST_STUFF) begin
            hb_in[0] = '0;
            hb_in[1] = '0;
        end else if (mode_q == MODE_R2C) begin
            hb_in[0] = mix_i;
            hb_in[1] = mix_q;
        end else begin
            hb_in[0] = LANE_W'(signed'(in_i));
            hb_in[1] = LANE_W'(signed'(in_q));
        end
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        fs4_halfband #(.W(LANE_W), .ACC_W(ACC_W)) u_hb (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .push  (push),
            .din   (hb_in[ln]),
            .acc   (hb_acc[ln])
        );
        assign rnd_r2c[ln] = (hb_acc[ln] + ACC_W'(1 << (SH_R2C - 1))) >>> SH_R2C;
        assign rnd_c2r[ln] = (hb_acc[ln] + ACC_W'(1 << (SH_C2R - 1))) >>> SH_C2R;
    end

    // up rotation, real part only
    fs4_mix_up #(.W(OUT_W)) u_up (
        .v_i  (OUT_W'(rnd_c2r[0])),
        .v_q  (OUT_W'(rnd_c2r[1])),
        .step (phase),
        .re   (up_re)
    );

    // output and mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_i  <= '0;
            res_q  <= '0;
            mode_q <= MODE_R2C;
            second <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE:  if (accept) second <= 1'b0;
                ST_FLUSH: mode_q <= mode_in;
                ST_STUFF: second <= 1'b1;
                ST_FILT: begin
                    if (mode_q == MODE_R2C) begin
                        res_i <= OUT_W'(rnd_r2c[0]);
                        res_q <= OUT_W'(rnd_r2c[1]);
                    end else begin
                        res_i <= up_re;
                        res_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign out_i = res_i;
    assign out_q = res_q;

endmodule

// File: rtl/fs4_format_conv_chk.sv
module fs4_format_conv_chk #(
    parameter int OUT_W  = 14,
    parameter int LANE_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OUT_W-1:0]  out_i,
    input logic [OUT_W-1:0]  out_q,
    input logic              mode_q,
    input logic              accept,
    input logic              clr,
    input logic [1:0]        phase,
    input logic [LANE_W-1:0] mix_i,
    input logic [LANE_W-1:0] mix_q
);
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q)); // R6

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R6

    AST_C2R_IMAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode_q |-> out_q == '0); // R5

    AST_DOWNMIX_ONE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !mode_q |-> (mix_i == '0 || mix_q == '0)); // R2

    AST_FLUSH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> phase == 2'd0); // R7

    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !in_ready); // R7

    AST_LATENCY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !out_valid); // R8

    AST_LATENCY_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 out_valid); // R8
endmodule

bind fs4_format_conv fs4_format_conv_chk #(.OUT_W(OUT_W), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_i     (out_i),
    .out_q     (out_q),
    .mode_q    (mode_q),
    .accept    (accept),
    .clr       (clr),
    .phase     (phase),
    .mix_i     (mix_i),
    .mix_q     (mix_q)
);

// File: tb/sim_fs4_format_conv.sv
`timescale 1ns/1ps
module sim_fs4_format_conv;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;
    localparam int OW = DW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DW-1:0] in_i = '0;
    logic [DW-1:0] in_q = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [OW-1:0] out_i, out_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    fs4_format_conv #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // scoreboard
    int    sb_i[$];
    int    sb_q[$];
    string sb_tag[$];

    // reference state
    int hi[7];
    int hq[7];
    int ph = 0;
    int cur_mode = 0;
    bit lat_chk = 0;
    bit bp_en = 0;
    int bp_cnt = 0;

    function automatic int tap(input int k);
        case (k)
            0, 6: return -1;
            2, 4: return 9;
            3:    return 16;
            default: return 0;
        endcase
    endfunction

    task automatic ref_clear();
        for (int k = 0; k < 7; k++) begin hi[k] = 0; hq[k] = 0; end
        ph = 0;
    endtask

    task automatic ref_shift(input int a, input int b);
        for (int k = 6; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
        hi[0] = a;
        hq[0] = b;
    endtask

    function automatic int acc_i();
        int s = 0;
        for (int k = 0; k < 7; k++) s += tap(k) * hi[k];
        return s;
    endfunction

    function automatic int acc_q();
        int s = 0;
        for (int k = 0; k < 7; k++) s += tap(k) * hq[k];
        return s;
    endfunction

    task automatic c2r_emit(input string tag);
        int vi, vq, re;
        vi = (acc_i() + 8) >>> 4;
        vq = (acc_q() + 8) >>> 4;
        case (ph)
            0: re = vi;
            1: re = -vq;
            2: re = -vi;
            default: re = vq;
        endcase
        sb_i.push_back(re); sb_q.push_back(0); sb_tag.push_back(tag);
        ph = (ph + 1) % 4;
    endtask

    task automatic drive(input int m, input int a, input int b);
        @(negedge clk);
        mode = m[0];
        in_i = DW'(a);
        in_q = DW'(b);
        in_valid = 1'b1;
        forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (lat_chk) begin
            #1 check(out_valid == 1'b0, "R8 early", int'(out_valid), 0);
            @(negedge clk);
            #1 check(out_valid == 1'b1, "R8 due", int'(out_valid), 1);
        end
    endtask

    task automatic send_r2c(input int x, input string tag);
        int mi, mq;
        if (cur_mode != 0) begin ref_clear(); cur_mode = 0; end
        case (ph)
            0: begin mi = x;  mq = 0;  end
            1: begin mi = 0;  mq = -x; end
            2: begin mi = -x; mq = 0;  end
            default: begin mi = 0; mq = x; end
        endcase
        ph = (ph + 1) % 4;
        ref_shift(mi, mq);
        sb_i.push_back((acc_i() + 16) >>> 5);
        sb_q.push_back((acc_q() + 16) >>> 5);
        sb_tag.push_back(tag);
        drive(0, x, 0);
    endtask

    task automatic send_c2r(input int a, input int b, input string tag);
        if (cur_mode != 1) begin ref_clear(); cur_mode = 1; end
        ref_shift(a, b);
        c2r_emit(tag);
        ref_shift(0, 0);
        c2r_emit(tag);
        drive(1, a, b);
    endtask

    // monitor: sets out_ready, then compares what the next edge will take
    bit   held = 0;
    logic [OW-1:0] held_i, held_q;
    always @(negedge clk) begin
        if (rst_n) begin
            bp_cnt++;
            out_ready = bp_en ? ((bp_cnt % 3) != 0) : 1'b1;
            if (held) begin
                check(out_valid == 1'b1, "R6 valid held", int'(out_valid), 1);
                check(out_i == held_i && out_q == held_q, "R6 data held",
                      int'($signed(out_i)), int'($signed(held_i)));
            end
            held = 0;
            if (out_valid) begin
                check(in_ready == 1'b0, "R6 in_ready low while busy", int'(in_ready), 0);
                if (out_ready) begin
                    if (sb_i.size() == 0) begin
                        check(1'b0, "scoreboard underflow", 0, 0);
                    end else begin
                        int ei, eq;
                        string t;
                        ei = sb_i.pop_front();
                        eq = sb_q.pop_front();
                        t  = sb_tag.pop_front();
                        check(int'($signed(out_i)) == ei, {t, " out_i"}, int'($signed(out_i)), ei);
                        check(int'($signed(out_q)) == eq, {t, " out_q"}, int'($signed(out_q)), eq);
                    end
                end else begin
                    held = 1;
                    held_i = out_i;
                    held_q = out_q;
                end
            end
        end
    end

    task automatic drain();
        while (sb_i.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        ref_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);

        // impulse, rotation and filter, with latency probe
        lat_chk = 1;
        send_r2c(1000, "R2 R3 R1 impulse");
        lat_chk = 0;
        for (int n = 0; n < 8; n++) send_r2c(0, "R3 impulse tail");

        // constant input exercises all four rotation steps
        for (int n = 0; n < 8; n++) send_r2c(700, "R2 constant");

        // ramp under backpressure
        bp_en = 1;
        for (int n = 0; n < 10; n++) send_r2c(n * 97 - 400, "R3 R6 ramp");
        bp_en = 0;
        drain();

        // mode change: ready must drop immediately
        @(negedge clk);
        mode = 1'b1;
        #1 check(in_ready == 1'b0, "R7 ready drop", int'(in_ready), 0);

        lat_chk = 1;
        send_c2r(1000, -500, "R4 R5 impulse");
        lat_chk = 0;
        for (int n = 0; n < 5; n++) send_c2r(0, 0, "R4 R5 tail");

        bp_en = 1;
        for (int n = 0; n < 8; n++) send_c2r(300 * (n % 3) - 200, 150 - 60 * n, "R5 R6 mixed");
        bp_en = 0;
        drain();

        // back to real-to-complex: history must be gone
        send_r2c(1000, "R7 flushed impulse");
        for (int n = 0; n < 6; n++) send_r2c(0, "R7 flushed tail");

        // full scale in both modes
        for (int n = 0; n < 8; n++) send_r2c((n % 2 == 0) ? -2048 : 2047, "R9 r2c full scale");
        for (int n = 0; n < 6; n++) send_r2c(-2048, "R9 r2c negative rail");
        for (int n = 0; n < 6; n++)
            send_c2r((n % 2 == 0) ? -2048 : 2047, (n % 2 == 0) ? 2047 : -2048, "R9 c2r full scale");
        for (int n = 0; n < 4; n++) send_c2r(-2048, -2048, "R9 c2r negative rail");
        drain();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", sb_i.size(), 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule